// File: doc/BRIEF.md
# SD Command-Line Response Receiver

This block captures a response frame sent by an SD card on its bidirectional command line, one bit per system clock. A controller that has just issued a command pulses the arm input for one cycle and presents a response-type code with it. The receiver stores that code, waits for the line to drop from its idle-high level, and then shifts in a frame whose length depends on the stored code.

When the last bit has been stored, the receiver raises a completion flag and presents the frame on a 136-bit parallel output. A long frame fills the whole output word. A short frame is right-aligned, and the bits above it read as zero. The completion flag and the data keep their values until the next arm pulse. A busy output covers the time from arming until completion.

Generating the card clock, sending commands, checking the CRC and decoding response fields all belong to other blocks.

Top module: `sd_resp_rx`

## Requirements
- R1: While reset is high at a rising clock edge (synchronous, active high), the block clears `done_o`, `busy_o` and `frame_o` to zero and returns to idle.
- R2: While the block is not armed, changes on `cmd_i` have no effect on `frame_o`, `done_o` or `busy_o`.
- R3: A cycle with `arm_i` high clears `done_o` and `frame_o` and raises `busy_o`. These values are visible in the following cycle.
- R4: `rtype_i` is sampled only in the arm cycle. Changing it later does not alter the length of the frame being captured.
- R5: After arming, the block keeps waiting while `cmd_i` is 1. The first 0 that follows is the start bit, and it becomes the most significant bit of the captured frame.
- R6: Response-type code 2 selects a 136-bit frame. Bits are stored most significant first, one per rising edge, and the frame fills `frame_o[135:0]`.
- R7: Response-type code 3 selects a 48-bit frame. The frame fills `frame_o[47:0]`, and `frame_o[135:48]` read as zero.
- R8: Every code other than 2 (0, 1 and 4 to 7) selects the 48-bit length.
- R9: `done_o` is registered. It goes high in the clock cycle right after the cycle in which the final frame bit was on `cmd_i`. `busy_o` falls at the same time, and the two are never high together.
- R10: Once set, `done_o` and `frame_o` hold their values until the next arm pulse or reset.
- R11: An arm pulse that arrives while a capture is in progress abandons that capture and starts a new wait for a start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; `cmd_i` is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| arm_i | input | 1 | One-cycle pulse that starts a new capture |
| rtype_i | input | 3 | Response-type code, valid only while `arm_i` is high |
| cmd_i | input | 1 | Serial command line, idle high |
| frame_o | output | 136 | Captured frame, right-aligned |
| done_o | output | 1 | Frame complete; held until the next arm pulse |
| busy_o | output | 1 | High from arming until completion |

## Verification
The arm pulse affects `busy_o`, `done_o` and `frame_o` one cycle later. Each bit on `cmd_i` appears in `frame_o` one cycle after it is driven. `done_o` rises in the cycle after the final bit was on the line. The bench drives inputs just after the falling edge. A behavioural model in the bench updates on every rising edge, and the design is compared with that model at the next falling edge, so every due value is checked in the exact cycle it must appear. Extra checks compare the frame against fixed expected words after each completion, after idle toggling of the line, and after a restart in the middle of a frame.

// File: rtl/sd_resp_rx_pkg.sv
package sd_resp_rx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_SHIFT = 2'd2
    } rx_state_e;
endpackage

// File: rtl/sd_resp_len_dec.sv
module sd_resp_len_dec #(
    parameter int TYPE_W    = 3,
    parameter int LONG_CODE = 2,
    parameter int LONG_LEN  = 136,
    parameter int SHORT_LEN = 48,
    parameter int CNT_W     = 8
) (
    input  logic [TYPE_W-1:0] code_i,
    output logic [CNT_W-1:0]  len_o
);
    always_comb begin
        if (code_i == TYPE_W'(LONG_CODE)) len_o = CNT_W'(LONG_LEN);
        else                              len_o = CNT_W'(SHORT_LEN);
    end
endmodule

// File: rtl/sd_resp_shifter.sv
module sd_resp_shifter #(
    parameter int WIDTH = 136
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             shift_i,
    input  logic             bit_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (clr_i)        sr_d = '0;
        else if (shift_i) sr_d = {sr_q[WIDTH-2:0], bit_i};
    end

    always_ff @(posedge clk) begin
        if (rst) sr_q <= '0;
        else     sr_q <= sr_d;
    end

    assign q_o = sr_q;
endmodule

// File: rtl/sd_resp_rx.sv
module sd_resp_rx
    import sd_resp_rx_pkg::*;
#(
    parameter int FRAME_W   = 136,
    parameter int TYPE_W    = 3,
    parameter int LONG_CODE = 2,
    parameter int SHORT_LEN = 48,
    localparam int CNT_W    = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               arm_i,
    input  logic [TYPE_W-1:0]  rtype_i,
    input  logic               cmd_i,
    output logic [FRAME_W-1:0] frame_o,
    output logic               done_o,
    output logic               busy_o
);
    typedef struct packed {
        rx_state_e        st;
        logic [CNT_W-1:0] len;
        logic [CNT_W-1:0] cnt;
        logic             done;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    logic [CNT_W-1:0] len_sel;
    logic             sh_clr, sh_en;

    sd_resp_len_dec #(
        .TYPE_W   (TYPE_W),
        .LONG_CODE(LONG_CODE),
        .LONG_LEN (FRAME_W),
        .SHORT_LEN(SHORT_LEN),
        .CNT_W    (CNT_W)
    ) u_len (
        .code_i(rtype_i),
        .len_o (len_sel)
    );

    always_comb begin
        ctl_d  = ctl_q;
        sh_clr = 1'b0;
        sh_en  = 1'b0;
        if (arm_i) begin
            ctl_d.st   = ST_WAIT;
            ctl_d.len  = len_sel;
            ctl_d.cnt  = '0;
            ctl_d.done = 1'b0;
            sh_clr     = 1'b1;
        end else begin
            case (ctl_q.st)
                ST_WAIT: begin
                    if (!cmd_i) begin
                        sh_en     = 1'b1;
                        ctl_d.cnt = ctl_q.len - CNT_W'(1);
                        ctl_d.st  = ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    sh_en     = 1'b1;
                    ctl_d.cnt = ctl_q.cnt - CNT_W'(1);
                    if (ctl_q.cnt == CNT_W'(1)) begin
                        ctl_d.st   = ST_IDLE;
                        ctl_d.done = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.st   <= ST_IDLE;
            ctl_q.len  <= '0;
            ctl_q.cnt  <= '0;
            ctl_q.done <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    sd_resp_shifter #(.WIDTH(FRAME_W)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (sh_clr),
        .shift_i(sh_en),
        .bit_i  (cmd_i),
        .q_o    (frame_o)
    );

    assign done_o = ctl_q.done;
    assign busy_o = (ctl_q.st != ST_IDLE);
endmodule

// File: rtl/sd_resp_rx_chk.sv
module sd_resp_rx_chk #(
    parameter int FRAME_W = 136
) (
    input logic               clk,
    input logic               rst,
    input logic               arm_i,
    input logic [FRAME_W-1:0] frame_o,
    input logic               done_o,
    input logic               busy_o
);
    p_busy_done_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(busy_o && done_o));

    p_done_from_busy_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> $past(busy_o));

    p_arm_clears_r3: assert property (@(posedge clk) disable iff (rst)
        arm_i |=> (busy_o && !done_o && frame_o == '0));

    p_idle_stable_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !arm_i) |=> ($stable(frame_o) && $stable(done_o) && !busy_o));

    p_done_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (done_o && !arm_i) |=> done_o);
endmodule

bind sd_resp_rx sd_resp_rx_chk #(.FRAME_W(FRAME_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .arm_i  (arm_i),
    .frame_o(frame_o),
    .done_o (done_o),
    .busy_o (busy_o)
);

// File: tb/sd_resp_rx_tb_top.sv
module sd_resp_rx_tb_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         arm_i = 1'b0;
    logic [2:0]   rtype_i = 3'd0;
    logic         cmd_i = 1'b1;
    logic [135:0] frame_o;
    logic         done_o, busy_o;

    int n_chk = 0, n_fail = 0;
    string cur_req = "R1";
    bit watchdog_hit = 1'b0;

    sd_resp_rx dut_i (
        .clk(clk), .rst(rst), .arm_i(arm_i), .rtype_i(rtype_i),
        .cmd_i(cmd_i), .frame_o(frame_o), .done_o(done_o), .busy_o(busy_o)
    );

    always #2.5 clk = ~clk;

    // behavioural reference model
    logic [135:0] m_frame = '0;
    bit m_busy = 0, m_done = 0, m_shifting = 0;
    int m_len = 0, m_left = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_frame = '0; m_busy = 0; m_done = 0; m_shifting = 0; m_left = 0;
        end else if (arm_i) begin
            m_frame = '0; m_busy = 1; m_done = 0; m_shifting = 0;
            m_len = (rtype_i == 3'd2) ? 136 : 48;
        end else if (m_busy) begin
            if (!m_shifting) begin
                if (cmd_i == 1'b0) begin
                    m_frame = {m_frame[134:0], 1'b0};
                    m_left = m_len - 1;
                    m_shifting = 1;
                end
            end else begin
                m_frame = {m_frame[134:0], cmd_i};
                m_left = m_left - 1;
                if (m_left == 0) begin
                    m_busy = 0; m_done = 1; m_shifting = 0;
                end
            end
        end
    end

    task automatic check(string req, logic [135:0] act, logic [135:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            check({cur_req, " frame"}, frame_o, m_frame);
            check({cur_req, " done"}, 136'(done_o), 136'(m_done));
            check({cur_req, " busy"}, 136'(busy_o), 136'(m_busy));
        end
    end

    task automatic step(int n);
        repeat (n) begin @(negedge clk); #0.5; end
    endtask

    task automatic arm(logic [2:0] code);
        @(negedge clk); #0.5;
        arm_i = 1'b1; rtype_i = code;
        @(negedge clk); #0.5;
        arm_i = 1'b0; rtype_i = 3'd0;
    endtask

    task automatic send(logic [135:0] v, int n);
        for (int i = n - 1; i >= 0; i--) begin
            cmd_i = v[i];
            @(negedge clk); #0.5;
        end
        cmd_i = 1'b1;
    endtask

    logic [135:0] long_w  = {8'h01, {15{8'hAA}}, 8'h01};
    logic [135:0] short_w = 136'h00ABCDEF1201;
    logic [135:0] short2  = 136'h3F5A5A0F0F81;

    initial begin
        step(3);
        // checks after reset
        check("R1 frame", frame_o, '0);
        check("R1 done", 136'(done_o), 0);
        check("R1 busy", 136'(busy_o), 0);
        rst = 1'b0;

        cur_req = "R2";
        for (int i = 0; i < 10; i++) begin cmd_i = i[0]; step(1); end
        cmd_i = 1'b1;
        check("R2 idle frame", frame_o, '0);
        check("R2 idle busy", 136'(busy_o), 0);

        cur_req = "R6";
        arm(3'd2);
        check("R3 busy after arm", 136'(busy_o), 1);
        step(4);
        check("R5 still waiting", 136'(busy_o), 1);
        send(long_w, 136);
        check("R9 done after long", 136'(done_o), 1);
        check("R9 busy low", 136'(busy_o), 0);
        check("R6 long frame", frame_o, long_w);

        cur_req = "R10";
        for (int i = 0; i < 12; i++) begin cmd_i = ~i[1]; step(1); end
        cmd_i = 1'b1;
        check("R10 frame held", frame_o, long_w);
        check("R10 done held", 136'(done_o), 1);

        cur_req = "R7";
        @(negedge clk); #0.5;
        arm_i = 1'b1; rtype_i = 3'd3;
        @(negedge clk); #0.5;
        arm_i = 1'b0; rtype_i = 3'd2;   // later change must be ignored (R4)
        check("R3 done cleared", 136'(done_o), 0);
        check("R3 frame cleared", frame_o, '0);
        step(2);
        send(short_w, 48);
        check("R7 short frame", frame_o, short_w);
        check("R4 length latched", 136'(done_o), 1);
        rtype_i = 3'd0;

        cur_req = "R8";
        arm(3'd5);
        send(short2, 48);
        check("R8 code 5 short", frame_o, short2);
        check("R8 done", 136'(done_o), 1);

        cur_req = "R11";
        arm(3'd2);
        send(136'h0F, 20);              // partial long capture
        check("R11 busy mid", 136'(busy_o), 1);
        arm(3'd3);
        step(3);
        send(short_w, 48);
        check("R11 restart frame", frame_o, short_w);
        check("R11 restart done", 136'(done_o), 1);

        cur_req = "R1";
        rst = 1'b1;
        step(2);
        check("R1 reset frame", frame_o, '0);
        check("R1 reset done", 136'(done_o), 0);
        rst = 1'b0;
        step(2);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #500000;
        watchdog_hit = 1'b1;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule